// File: doc/BRIEF.md
# Peripheral Clock-Gate and Reset Controller

This block keeps two 32-bit control words behind a small register bus. One word holds a clock-enable bit for each peripheral slot and the other holds a reset bit for each slot. The block drives a gate-enable output and a reset output for every slot. The reset outputs are driven only for the slots that have a peripheral attached. Some reset bits serve more than one unit. Bit 10 covers both the AES engine and the PECI controller, bit 11 covers both UARTs, and bit 12 covers the memory controller.

The block also wraps the read path of one peripheral. That peripheral is modelled as a small bank of registers with known start values. While its slot is clock-gated, the bank returns zero on every read and keeps what was written to it. While its slot is held in reset, the bank returns a fixed value chosen per slot: all-ones for slots that float high, zero for the others. When the reset is released, the bank starts again from its initial values.

The wrapped slot, the per-slot reset read value and the address layout are parameters. A chip uses one instance for each peripheral it wraps.

Top module: `pgr_ctrl`

## Requirements
- R1: While `rst_n` is low and after it rises, the gate word reads 0xFFFFFFFF and the reset word reads 0x00000000. `clk_en_o` is all-ones, `rst_o` is all-zeros, and bank register k holds 0x5A000000 | (k*0x11).
- R2: A bus write to byte address 0x00 stores the full gate word, and a write to 0x20 stores the full reset word. A read of either address returns the stored word on `bus_rdata` with `bus_rvalid` high in the cycle after the request.
- R3: `clk_en_o[i]` equals bit i of the gate word. Bit 11 is the UART0 enable and bit 12 is the UART1 enable.
- R4: `rst_o[i]` equals bit i of the reset word for every attached slot. Reset bits 1, 2, 4, 17 and 20 to 26 have no attached slot. They are stored and read back, but their `rst_o` bits stay 0.
- R5: A read of the window (byte addresses WIN_BASE + 4*k, default 0x40 to 0x4C) returns 0 while gate bit WRAP_SLOT is 0 and reset bit WRAP_SLOT is 0. Once the gate bit is set again, the values written earlier read back unchanged.
- R6: While reset bit WRAP_SLOT is 1, a window read returns 0xFFFFFFFF if bit WRAP_SLOT of RST_ONES is 1, and 0 otherwise. The default RST_ONES is 0x00000001. After the reset bit is cleared, the bank reads its R1 initial values.
- R7: A window write is ignored while the wrapped slot is gated or held in reset.
- R8: A read of any address that is not mapped returns 0. A write to such an address changes no register.
- R9: When the wrapped slot is both gated and held in reset, a window read returns the reset read value of R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| bus_sel | input | 1 | Bus request this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, one cycle after the request |
| bus_rvalid | output | 1 | High in the cycle in which bus_rdata holds a read result |
| clk_en_o | output | DATA_W | Per-slot clock-gate enable |
| rst_o | output | DATA_W | Per-slot reset, masked to attached slots |

## Verification
The bench targets several specific failure modes:
- It gates the wrapped slot and then writes to its window. A design that let that write through would show the new data after ungating instead of the old contents.
- It holds reset on two instances whose slots have different reset read values. A design with a fixed reset value would return all-ones where zero is required.
- It clears the gate bit while reset is held. A design that checks the gate before the reset would return zero instead of all-ones.
- It sets only the unattached reset bits. A design without the attached-slot mask would raise `rst_o` on those bits.
- After reset release, it checks that the bank holds its initial values, not the contents it had before the reset.

// File: rtl/pgr_pkg.sv
package pgr_pkg;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_GATE = 2'd1,
        SEL_RST  = 2'd2,
        SEL_WIN  = 2'd3
    } sel_e;

    // Start value of wrapped register k after power-on or slot reset
    function automatic logic [31:0] bank_init(input int unsigned k);
        return 32'h5A00_0000 | (k * 32'h11);
    endfunction

endpackage

// File: rtl/pgr_ctrl_regs.sv
module pgr_ctrl_regs #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_gate,
    input  logic              wr_rst,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] gate_q,
    output logic [DATA_W-1:0] rstw_q
);

    typedef struct packed {
        logic [DATA_W-1:0] gate;
        logic [DATA_W-1:0] rstw;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_gate) st_d.gate = wdata;
        if (wr_rst)  st_d.rstw = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.gate <= '1;
            st_q.rstw <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gate_q = st_q.gate;
    assign rstw_q = st_q.rstw;

    a_r2_gate_write_stored: assert property (@(posedge clk) disable iff (!rst_n)
        wr_gate |=> gate_q == $past(wdata));

    a_r2_rst_write_stored: assert property (@(posedge clk) disable iff (!rst_n)
        wr_rst |=> rstw_q == $past(wdata));

endmodule

// File: rtl/pgr_periph_bank.sv
module pgr_periph_bank #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned NREG   = 4,
    localparam int unsigned IDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              hold_rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_data
);

    function automatic logic [NREG-1:0][DATA_W-1:0] init_vec();
        logic [NREG-1:0][DATA_W-1:0] v;
        for (int unsigned k = 0; k < NREG; k++) begin
            v[k] = DATA_W'(pgr_pkg::bank_init(k));
        end
        return v;
    endfunction

    localparam logic [NREG-1:0][DATA_W-1:0] INIT_V = init_vec();

    logic [NREG-1:0][DATA_W-1:0] regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (hold_rst) begin
            regs_d = INIT_V;
        end else if (wr_en && clk_en) begin
            regs_d[idx] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= INIT_V;
        else        regs_q <= regs_d;
    end

    assign rd_data = regs_q[idx];

    // R7: a write into a gated bank leaves its contents alone
    a_r7_gated_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clk_en && !hold_rst) |=> $stable(regs_q));

    // R6: a held reset puts the bank at its start values
    a_r6_reset_to_init: assert property (@(posedge clk) disable iff (!rst_n)
        hold_rst |=> regs_q == INIT_V);

endmodule

// File: rtl/pgr_read_wrap.sv
module pgr_read_wrap #(
    parameter int unsigned DATA_W   = 32,
    parameter bit          RST_READ = 1'b1
) (
    input  logic              gate_on,
    input  logic              in_rst,
    input  logic [DATA_W-1:0] raw,
    output logic [DATA_W-1:0] masked
);

    logic [DATA_W-1:0] rst_val;

    generate
        if (RST_READ) begin : g_float_high
            assign rst_val = '1;
        end else begin : g_float_low
            assign rst_val = '0;
        end
    endgenerate

    // Reset wins over gating (R9)
    always_comb begin
        if (in_rst)        masked = rst_val;
        else if (!gate_on) masked = '0;
        else               masked = raw;
    end

endmodule

// File: rtl/pgr_ctrl.sv
module pgr_ctrl #(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned NREG      = 4,
    parameter int unsigned WRAP_SLOT = 0,
    parameter logic [DATA_W-1:0] RST_ONES = 32'h0000_0001,
    parameter logic [DATA_W-1:0] ATTACHED = 32'hF80D_FFE9,
    parameter logic [ADDR_W-1:0] GATE_OFF = 8'h00,
    parameter logic [ADDR_W-1:0] RST_OFF  = 8'h20,
    parameter logic [ADDR_W-1:0] WIN_BASE = 8'h40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    output logic [DATA_W-1:0] clk_en_o,
    output logic [DATA_W-1:0] rst_o
);
    import pgr_pkg::*;

    localparam int unsigned IDX_W   = (NREG > 1) ? $clog2(NREG) : 1;
    localparam int unsigned WIN_LSB = IDX_W + 2;
    localparam bit          RST_HI  = RST_ONES[WRAP_SLOT];

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
    } rd_t;

    sel_e              sel;
    logic              wr, rd;
    logic [DATA_W-1:0] gate_w, rstw_w, bank_rd, win_rd;
    rd_t               rd_d, rd_q;

    assign wr = bus_sel &&  bus_wr;
    assign rd = bus_sel && !bus_wr;

    always_comb begin
        sel = SEL_NONE;
        if (bus_addr == GATE_OFF) begin
            sel = SEL_GATE;
        end else if (bus_addr == RST_OFF) begin
            sel = SEL_RST;
        end else if (bus_addr[ADDR_W-1:WIN_LSB] == WIN_BASE[ADDR_W-1:WIN_LSB]
                     && bus_addr[1:0] == 2'b00) begin
            sel = SEL_WIN;
        end
    end

    pgr_ctrl_regs #(.DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_gate (wr && sel == SEL_GATE),
        .wr_rst  (wr && sel == SEL_RST),
        .wdata   (bus_wdata),
        .gate_q  (gate_w),
        .rstw_q  (rstw_w)
    );

    pgr_periph_bank #(.DATA_W(DATA_W), .NREG(NREG)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .clk_en   (gate_w[WRAP_SLOT]),
        .hold_rst (rstw_w[WRAP_SLOT]),
        .wr_en    (wr && sel == SEL_WIN),
        .idx      (bus_addr[WIN_LSB-1:2]),
        .wdata    (bus_wdata),
        .rd_data  (bank_rd)
    );

    pgr_read_wrap #(.DATA_W(DATA_W), .RST_READ(RST_HI)) u_wrap (
        .gate_on (gate_w[WRAP_SLOT]),
        .in_rst  (rstw_w[WRAP_SLOT]),
        .raw     (bank_rd),
        .masked  (win_rd)
    );

    always_comb begin
        rd_d        = rd_q;
        rd_d.rvalid = rd;
        if (rd) begin
            case (sel)
                SEL_GATE: rd_d.rdata = gate_w;
                SEL_RST:  rd_d.rdata = rstw_w;
                SEL_WIN:  rd_d.rdata = win_rd;
                default:  rd_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign bus_rdata  = rd_q.rdata;
    assign bus_rvalid = rd_q.rvalid;
    assign clk_en_o   = gate_w;
    assign rst_o      = rstw_w & ATTACHED;

    a_r2_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> bus_rvalid);

    a_r5_gated_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && sel == SEL_WIN && !clk_en_o[WRAP_SLOT] && !rstw_w[WRAP_SLOT])
        |=> bus_rdata == '0);

    a_r9_reset_read_value: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && sel == SEL_WIN && rstw_w[WRAP_SLOT])
        |=> bus_rdata == (RST_HI ? {DATA_W{1'b1}} : {DATA_W{1'b0}}));

    a_r8_unmapped_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && sel == SEL_NONE) |=> bus_rdata == '0);

endmodule

// File: tb/test_pgr_ctrl.sv
module test_pgr_ctrl;

    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rdata_a, rdata_b, clk_en_a, clk_en_b, rst_a, rst_b;
    logic        rvalid_a, rvalid_b;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Slot 0 floats high in reset; slot 6 reads zero in reset
    pgr_ctrl i_pgr_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_a),
        .bus_rvalid(rvalid_a), .clk_en_o(clk_en_a), .rst_o(rst_a)
    );

    pgr_ctrl #(.WRAP_SLOT(6)) i_pgr_ctrl_b (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_b),
        .bus_rvalid(rvalid_b), .clk_en_o(clk_en_b), .rst_o(rst_b)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Reference state built from the requirements
    logic [31:0] gate_m, rst_m;
    logic [31:0] bank_m [2][4];
    int          slot_of [2] = '{0, 6};
    bit          ones_of [2] = '{1'b1, 1'b0};

    logic [31:0] exp_a_q [$];
    logic [31:0] exp_b_q [$];
    string       tag_q   [$];

    function automatic logic [31:0] init_of(input int k);
        return 32'h5A00_0000 | (k * 32'h11);
    endfunction

    function automatic bit is_win(input logic [7:0] a);
        return a[7:4] == 4'h4 && a[1:0] == 2'b00;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input int i, input logic [7:0] a);
        if (a == 8'h00) return gate_m;
        if (a == 8'h20) return rst_m;
        if (is_win(a)) begin
            if (rst_m[slot_of[i]])   return ones_of[i] ? 32'hFFFF_FFFF : 32'h0;
            if (!gate_m[slot_of[i]]) return 32'h0;
            return bank_m[i][a[3:2]];
        end
        return 32'h0;
    endfunction

    task automatic model_write(input logic [7:0] a, input logic [31:0] d);
        if (a == 8'h00) begin
            gate_m = d;
        end else if (a == 8'h20) begin
            rst_m = d;
            for (int i = 0; i < 2; i++)
                if (d[slot_of[i]])
                    for (int k = 0; k < 4; k++) bank_m[i][k] = init_of(k);
        end else if (is_win(a)) begin
            for (int i = 0; i < 2; i++)
                if (gate_m[slot_of[i]] && !rst_m[slot_of[i]]) bank_m[i][a[3:2]] = d;
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        model_write(a, d);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, input string tag);
        exp_a_q.push_back(exp_read(0, a));
        exp_b_q.push_back(exp_read(1, a));
        tag_q.push_back(tag);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic read_window(input string tag);
        for (int k = 0; k < 4; k++) bus_read(8'h40 + 8'(4 * k), tag);
    endtask

    // Monitor: pops expectations as read results appear
    always @(negedge clk) begin
        if (rst_n && (rvalid_a || rvalid_b)) begin
            checks++;
            if (!(rvalid_a && rvalid_b) || tag_q.size() == 0) begin
                errors++;
                $display("FAIL R2 unexpected rvalid actual=%b%b expected=11 pending=%0d",
                         rvalid_a, rvalid_b, tag_q.size());
            end else begin
                string t;
                t = tag_q.pop_front();
                check({t, " slot0"}, rdata_a, exp_a_q.pop_front());
                check({t, " slot6"}, rdata_b, exp_b_q.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        gate_m = 32'hFFFF_FFFF;
        rst_m  = 32'h0;
        for (int i = 0; i < 2; i++)
            for (int k = 0; k < 4; k++) bank_m[i][k] = init_of(k);

        repeat (3) @(negedge clk);
        check("R1 clk_en during reset", clk_en_a, 32'hFFFF_FFFF);
        check("R1 rst_o during reset", rst_a, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R2: reset values through the bus
        bus_read(8'h00, "R1 gate word");
        bus_read(8'h20, "R1 reset word");
        read_window("R1 bank initial");

        // R2: window writes and read-back
        for (int k = 0; k < 4; k++) bus_write(8'h40 + 8'(4 * k), 32'hC0DE_0000 + 32'(k));
        read_window("R2 window readback");

        // R3: gate bits reach clk_en_o (bit 11 UART0, bit 12 UART1)
        bus_write(8'h00, 32'hFFFF_E7FF);
        check("R3 uart gates", clk_en_a, 32'hFFFF_E7FF);
        bus_read(8'h00, "R2 gate word readback");

        // R5 / R7: gate slots 0 and 6, write is ignored, old data returns
        bus_write(8'h00, 32'hFFFF_FFBE);
        check("R3 clk_en slot gates", clk_en_a, 32'hFFFF_FFBE);
        read_window("R5 gated read zero");
        bus_write(8'h44, 32'hDEAD_BEEF);
        bus_write(8'h00, 32'hFFFF_FFFF);
        read_window("R7 gated write ignored");

        // R4: unattached reset bits stored but not driven
        bus_write(8'h20, 32'h07F2_0016);
        check("R4 unattached rst_o", rst_a, 32'h0);
        bus_read(8'h20, "R4 unattached stored");

        // R4 / R6: shared reset bits and per-slot reset read value
        bus_write(8'h20, 32'h0000_1C41);
        check("R4 attached rst_o", rst_a, 32'h0000_1C41);
        check("R4 attached rst_o b", rst_b, 32'h0000_1C41);
        read_window("R6 reset read value");
        bus_write(8'h48, 32'h1234_5678);
        // R9: gated and in reset together
        bus_write(8'h00, 32'hFFFF_FFBE);
        read_window("R9 reset over gate");
        bus_write(8'h00, 32'hFFFF_FFFF);

        // R6: release returns initial values
        bus_write(8'h20, 32'h0);
        check("R6 rst_o released", rst_a, 32'h0);
        read_window("R6 initial after release");

        // R8: unmapped addresses
        bus_write(8'h80, 32'h0000_0000);
        bus_write(8'h41, 32'hFFFF_0000);
        bus_read(8'h80, "R8 unmapped read");
        bus_read(8'h41, "R8 unaligned read");
        bus_read(8'h00, "R8 gate unchanged");
        bus_read(8'h20, "R8 reset unchanged");
        read_window("R8 bank unchanged");

        repeat (3) @(negedge clk);
        checks++;
        if (tag_q.size() != 0) begin
            errors++;
            $display("FAIL R2 missing read results actual=%0d expected=0", tag_q.size());
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule